// File: doc/BRIEF.md
# Control-Register Bus Handshake Master

This block sits between a simple request port and the narrow control-register bus found inside a serial PHY. A requester asks for a single read or write with a 16-bit address and, for a write, 16-bit data. The block turns that request into a chain of separate phases on the bus. Each phase drives the shared data-in lines, lets them settle, raises one strobe and then completes a full four-phase handshake with the target's acknowledge line.

A write uses three phases: capture the address, capture the data, then issue the write command. A read uses two: capture the address, then issue the read command with data-in cleared to zero. The read value is taken from the target's data-out lines while acknowledge is high. Every wait for an acknowledge edge has its own timeout. If a wait runs out, the access stops at once and an error pulse replaces the done pulse. The acknowledge input passes through a synchroniser, because the target may run on an unrelated clock.

Top module: `crbus_master`

## Requirements
- R1: `req_ready` is high only while the engine is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from that cycle until the cycle after the single-cycle done or error pulse, when it is high again.
- R2: The address phase drives the request address on `cr_din` for at least SETUP_CYC (2) cycles before `cr_cap_addr` rises. The strobe then stays high until acknowledge is seen high. After the strobe drops, `cr_din` does not change until acknowledge has gone low.
- R3: A write runs its phases in this order: address capture, data capture, write command. The data phase drives the write data on `cr_din` with the same setup and handshake rules as R2. The write strobe rises with that data still on `cr_din`.
- R4: A read runs address capture and then the read command. `cr_din` is zero while `cr_read` is high. The value of `cr_dout`, sampled while acknowledge is high, is presented on `rsp_rdata` during the done pulse.
- R5: At most one of the four strobes is high in any cycle. All strobes are low while idle and during and after an error.
- R6: `cr_ack` reaches the sequencer through a two-flop synchroniser. With a target that answers a strobe at once, the strobe falls exactly 3 cycles after acknowledge rises.
- R7: Each wait for an acknowledge edge is limited to LIMIT = (CLK_HZ / 1,000,000) × TIMEOUT_US cycles, and the counter restarts for every wait. If acknowledge does not change, the error pulse comes exactly LIMIT cycles after the strobe rose. This applies to a wait for a rise and to a wait for a fall. Waits shorter than LIMIT succeed, even when the whole access takes longer than LIMIT.
- R8: On a timeout the access ends with `rsp_error` and no `rsp_done`, and no further strobe of that access is issued.
- R9: `rsp_done` and `rsp_error` are each one cycle long and never high together.
- R10: Addresses and data pass through unaltered across the whole range 0x0000 to 0xFFFF, including both end values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_done | output | 1 | One-cycle pulse: access completed |
| rsp_error | output | 1 | One-cycle pulse: acknowledge wait timed out |
| rsp_rdata | output | 16 | Read result, valid with `rsp_done` of a read |
| cr_din | output | 16 | Shared address/data lines to the target |
| cr_cap_addr | output | 1 | Address-capture strobe |
| cr_cap_data | output | 1 | Data-capture strobe |
| cr_read | output | 1 | Read-command strobe |
| cr_write | output | 1 | Write-command strobe |
| cr_ack | input | 1 | Acknowledge from the target (asynchronous) |
| cr_dout | input | 16 | Read data from the target |

## Verification
Writes and reads run against a bus target model that answers immediately, answers slowly with a 60-cycle delay per edge, never raises acknowledge, or raises it and never drops it. The immediate target pins down the synchroniser delay and the phase order. The slow target separates a counter that reloads on every wait from one that spans the whole access. The two stuck targets test the timeout on the rising wait and on the falling wait, and show that no later phase is issued. Accesses at addresses 0x0000 and 0xFFFF, and a read straight after an error, show that values pass through unaltered and that the engine recovers.

// File: rtl/crbus_pkg.sv
`timescale 1ns/1ps
package crbus_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RELEASE,
    ST_DONE,
    ST_ERROR
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_DATA,
    PH_CMD
  } phase_e;

  // Number of clock cycles allowed for one acknowledge wait.
  function automatic int unsigned wait_limit(int unsigned clk_hz, int unsigned tmo_us);
    return (clk_hz / 1000000) * tmo_us;
  endfunction

  // Bits needed to hold values 0 .. n-1.
  function automatic int unsigned count_bits(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/crbus_ack_sync.sv
`timescale 1ns/1ps
module crbus_ack_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/crbus_wait_timer.sv
`timescale 1ns/1ps
module crbus_wait_timer #(
  parameter int unsigned LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reload,
  output logic expired
);
  localparam int unsigned TW = crbus_pkg::count_bits(LIMIT);
  localparam logic [TW-1:0] START = TW'(LIMIT - 1);

  logic [TW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               remain <= START;
    else if (reload)          remain <= START;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/crbus_phase_seq.sv
`timescale 1ns/1ps
module crbus_phase_seq
  import crbus_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int SETUP_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  input  logic          ack_s,
  input  logic          tmo,
  input  logic [DW-1:0] cr_dout,
  output logic [DW-1:0] cr_din,
  output logic          cr_cap_addr,
  output logic          cr_cap_data,
  output logic          cr_read,
  output logic          cr_write,
  output logic          rsp_done,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_rdata,
  output logic          wait_active,
  output logic          wait_restart
);
  localparam int BW = (AW > DW) ? AW : DW;
  localparam int SW = $clog2(SETUP_CYC + 1);
  localparam logic [SW-1:0] SETUP_LAST = SW'(SETUP_CYC - 1);

  seq_state_e    state;
  phase_e        phase;
  logic          is_wr;
  logic [DW-1:0] wdata_q;
  logic [SW-1:0] setup_cnt;
  logic [BW-1:0] addr_ext;

  assign addr_ext = BW'(req_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      is_wr     <= 1'b0;
      wdata_q   <= '0;
      cr_din    <= '0;
      rsp_rdata <= '0;
      setup_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (req_valid) begin
          is_wr     <= req_write;
          wdata_q   <= req_wdata;
          cr_din    <= addr_ext[DW-1:0];
          phase     <= PH_ADDR;
          setup_cnt <= '0;
          state     <= ST_SETUP;
        end
        ST_SETUP: begin
          if (setup_cnt == SETUP_LAST) state <= ST_STROBE;
          else                         setup_cnt <= setup_cnt + 1'b1;
        end
        ST_STROBE: begin
          if (ack_s) begin
            if (phase == PH_CMD && !is_wr) rsp_rdata <= cr_dout;
            state <= ST_RELEASE;
          end else if (tmo) begin
            state <= ST_ERROR;
          end
        end
        ST_RELEASE: begin
          if (!ack_s) begin
            setup_cnt <= '0;
            case (phase)
              PH_ADDR: begin
                phase  <= is_wr ? PH_DATA : PH_CMD;
                cr_din <= is_wr ? wdata_q : '0;
                state  <= ST_SETUP;
              end
              PH_DATA: begin
                phase <= PH_CMD;
                state <= ST_SETUP;
              end
              default: state <= ST_DONE;
            endcase
          end else if (tmo) begin
            state <= ST_ERROR;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic strobe_on;
  assign strobe_on    = (state == ST_STROBE);
  assign cr_cap_addr  = strobe_on && (phase == PH_ADDR);
  assign cr_cap_data  = strobe_on && (phase == PH_DATA);
  assign cr_write     = strobe_on && (phase == PH_CMD) && is_wr;
  assign cr_read      = strobe_on && (phase == PH_CMD) && !is_wr;
  assign req_ready    = (state == ST_IDLE);
  assign rsp_done     = (state == ST_DONE);
  assign rsp_error    = (state == ST_ERROR);
  assign wait_active  = strobe_on || (state == ST_RELEASE);
  assign wait_restart = strobe_on && ack_s;

  p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cr_cap_addr, cr_cap_data, cr_read, cr_write}));
  p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !(cr_cap_addr || cr_cap_data || cr_read || cr_write));
  p_release_din_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RELEASE) |-> $stable(cr_din));
  p_read_zero_din_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cr_read |-> (cr_din == '0));
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_error));
  p_end_to_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || rsp_error) |=> req_ready);
  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/crbus_master.sv
`timescale 1ns/1ps
module crbus_master #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned TIMEOUT_US  = 1000,
  parameter int          SETUP_CYC   = 2,
  parameter int          SYNC_STAGES = 2,
  parameter int          AW          = 16,
  parameter int          DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_done,
  output logic          rsp_error,
  output logic [DW-1:0] rsp_rdata,
  output logic [DW-1:0] cr_din,
  output logic          cr_cap_addr,
  output logic          cr_cap_data,
  output logic          cr_read,
  output logic          cr_write,
  input  logic          cr_ack,
  input  logic [DW-1:0] cr_dout
);
  localparam int unsigned LIMIT = crbus_pkg::wait_limit(CLK_HZ, TIMEOUT_US);

  logic ack_s;
  logic tmo;
  logic wait_active;
  logic wait_restart;
  logic timer_reload;
  logic strobe_any;

  crbus_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (cr_ack),
    .sync_out (ack_s)
  );

  assign timer_reload = !wait_active || wait_restart;

  crbus_wait_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .reload  (timer_reload),
    .expired (tmo)
  );

  crbus_phase_seq #(.AW(AW), .DW(DW), .SETUP_CYC(SETUP_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_addr     (req_addr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .ack_s        (ack_s),
    .tmo          (tmo),
    .cr_dout      (cr_dout),
    .cr_din       (cr_din),
    .cr_cap_addr  (cr_cap_addr),
    .cr_cap_data  (cr_cap_data),
    .cr_read      (cr_read),
    .cr_write     (cr_write),
    .rsp_done     (rsp_done),
    .rsp_error    (rsp_error),
    .rsp_rdata    (rsp_rdata),
    .wait_active  (wait_active),
    .wait_restart (wait_restart)
  );

  assign strobe_any = cr_cap_addr || cr_cap_data || cr_read || cr_write;

  p_expire_error_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_any && !ack_s && tmo) |=> rsp_error);
  p_strobe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_any && !ack_s && !tmo) |=> strobe_any);
  p_error_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> !strobe_any);
endmodule

// File: tb/crbus_master_bench.sv
`timescale 1ns/1ps
module crbus_master_bench;
  localparam int LIMIT = 100; // 100 MHz, 1 us per wait

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_done, rsp_error;
  logic [15:0] rsp_rdata, cr_din;
  logic        cr_cap_addr, cr_cap_data, cr_read, cr_write;
  logic        cr_ack = 1'b0;
  logic [15:0] cr_dout = '0;

  crbus_master #(.CLK_HZ(100_000_000), .TIMEOUT_US(1)) u_crbus_master (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .cr_din(cr_din), .cr_cap_addr(cr_cap_addr), .cr_cap_data(cr_cap_data),
    .cr_read(cr_read), .cr_write(cr_write), .cr_ack(cr_ack), .cr_dout(cr_dout)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  // target model controls (written by tasks only)
  int mode = 0; // 0 normal, 1 ack never rises, 2 ack never falls
  int lat  = 0;

  // monitor state (written by monitor only)
  int          cyc = 0, lat_cnt = 0;
  int          rise_cnt = 0, wr_cnt = 0;
  int          viol_onehot = 0, viol_setup = 0, viol_stable = 0, viol_rdzero = 0;
  int          last_rise_cyc = 0, last_fall_cyc = 0, last_ack_rise = 0, err_cyc = 0;
  int          din_age = 0;
  logic        prev_any = 1'b0;
  logic [15:0] prev_din = '0;
  logic [15:0] order = '0;
  logic [15:0] t_addr = '0, t_data = '0, wr_addr = '0, wr_data = '0;

  function automatic logic [15:0] target_value(logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction

  always @(negedge clk) begin
    logic any;
    logic [3:0] code;
    cyc++;
    any = cr_cap_addr | cr_cap_data | cr_read | cr_write;
    if ($countones({cr_cap_addr, cr_cap_data, cr_read, cr_write}) > 1) viol_onehot++;
    if (cr_din != prev_din) begin
      if (any || prev_any || cr_ack) viol_stable++;
      din_age = 0;
    end else begin
      din_age++;
    end
    code = cr_cap_addr ? 4'h1 : cr_cap_data ? 4'h2 : cr_write ? 4'h3 : 4'h4;
    if (any && !prev_any) begin
      rise_cnt++;
      order = {order[11:0], code};
      last_rise_cyc = cyc;
      if (din_age < 2) viol_setup++;
    end
    if (!any && prev_any) last_fall_cyc = cyc;
    if (rsp_error) err_cyc = cyc;
    if (cr_read && cr_din != 16'h0000) viol_rdzero++;
    // bus target
    if (mode == 1) begin
      lat_cnt = 0;
    end else if (any && !cr_ack) begin
      if (lat_cnt >= lat) begin
        cr_ack = 1'b1;
        lat_cnt = 0;
        last_ack_rise = cyc;
        if (cr_cap_addr) t_addr = cr_din;
        if (cr_cap_data) t_data = cr_din;
        if (cr_write) begin wr_cnt++; wr_addr = t_addr; wr_data = cr_din; end
        if (cr_read) cr_dout = target_value(t_addr);
      end else lat_cnt++;
    end else if (!any && cr_ack && mode != 2) begin
      if (lat_cnt >= lat) begin cr_ack = 1'b0; lat_cnt = 0; end
      else lat_cnt++;
    end else begin
      lat_cnt = 0;
    end
    prev_any = any;
    prev_din = cr_din;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Issue one access; report outcome and handshake observations.
  task automatic run_access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                            output bit got_done, output bit got_err, output logic [15:0] rd,
                            output bit busy_ready, output bit pulse_ok, output bit ready_after);
    got_done = 0; got_err = 0; rd = '0; busy_ready = 0; pulse_ok = 1; ready_after = 0;
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (rsp_done || rsp_error) begin
        got_done = rsp_done; got_err = rsp_error; rd = rsp_rdata;
        if (rsp_done && rsp_error) pulse_ok = 0;
        break;
      end
      if (req_ready) busy_ready = 1;
      @(negedge clk);
    end
    @(negedge clk);
    if (rsp_done || rsp_error) pulse_ok = 0;
    ready_after = req_ready;
    @(posedge clk);
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check({cr_cap_addr, cr_cap_data, cr_read, cr_write} == 4'b0, "R5", "strobes after reset",
          {cr_cap_addr, cr_cap_data, cr_read, cr_write}, 0);
    check({rsp_done, rsp_error} == 2'b0, "R9", "pulses after reset", {rsp_done, rsp_error}, 0);
    check(cr_din == 16'h0, "R2", "din after reset", cr_din, 0);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [15:0] d);
    bit dn, er, br, po, ra; logic [15:0] rd; int w0, s0, st0, oh0;
    w0 = wr_cnt; s0 = viol_setup; st0 = viol_stable; oh0 = viol_onehot;
    run_access(1'b1, a, d, dn, er, rd, br, po, ra);
    check(dn && !er, "R3", "write completes", {dn, er}, 2'b10);
    check(order[11:0] == 12'h123, "R3", "write phase order", order[11:0], 12'h123);
    check(t_addr == a, "R10", "captured address", t_addr, a);
    check(wr_data == d && t_data == d, "R3", "written data", wr_data, d);
    check(wr_cnt == w0 + 1, "R3", "one write command", wr_cnt, w0 + 1);
    check(viol_setup == s0, "R2", "setup before strobe", viol_setup - s0, 0);
    check(viol_stable == st0, "R2", "din stable in handshake", viol_stable - st0, 0);
    check(viol_onehot == oh0, "R5", "single strobe", viol_onehot - oh0, 0);
    check(!br, "R1", "ready low while busy", br, 0);
    check(ra, "R1", "ready after done", ra, 1);
    check(po, "R9", "done one cycle", po, 1);
  endtask

  task automatic t_read(input logic [15:0] a);
    bit dn, er, br, po, ra; logic [15:0] rd; int z0;
    z0 = viol_rdzero;
    run_access(1'b0, a, 16'hFFFF, dn, er, rd, br, po, ra);
    check(dn && !er, "R4", "read completes", {dn, er}, 2'b10);
    check(order[7:0] == 8'h14, "R4", "read phase order", order[7:0], 8'h14);
    check(rd == target_value(a), "R4", "read data", rd, target_value(a));
    check(t_addr == a, "R10", "read address", t_addr, a);
    check(viol_rdzero == z0, "R4", "din zero on read", viol_rdzero - z0, 0);
    check(!br && ra && po, "R1", "read ready/pulse", {br, ra, po}, 3'b011);
  endtask

  task automatic t_sync_delay();
    lat = 0;
    t_write(16'h1234, 16'hBEEF);
    check(last_fall_cyc - last_ack_rise == 3, "R6", "strobe fall after ack",
          last_fall_cyc - last_ack_rise, 3);
  endtask

  task automatic t_slow_target();
    bit dn, er, br, po, ra; logic [15:0] rd; int c0;
    lat = 60;
    c0 = cyc;
    run_access(1'b1, 16'h0F0F, 16'hA55A, dn, er, rd, br, po, ra);
    check(dn && !er, "R7", "slow write within per-wait limit", {dn, er}, 2'b10);
    check(cyc - c0 > LIMIT, "R7", "access longer than one limit", cyc - c0, LIMIT);
    check(wr_data == 16'hA55A, "R3", "slow write data", wr_data, 16'hA55A);
    run_access(1'b0, 16'h7777, 16'h0, dn, er, rd, br, po, ra);
    check(dn && rd == target_value(16'h7777), "R7", "slow read", rd, target_value(16'h7777));
    lat = 0;
  endtask

  task automatic t_timeout_low();
    bit dn, er, br, po, ra; logic [15:0] rd; int r0;
    mode = 1;
    r0 = rise_cnt;
    run_access(1'b1, 16'h2222, 16'h3333, dn, er, rd, br, po, ra);
    check(er && !dn, "R8", "error not done on stuck-low ack", {dn, er}, 2'b01);
    check(err_cyc - last_rise_cyc == LIMIT, "R7", "rise-wait timeout cycles",
          err_cyc - last_rise_cyc, LIMIT);
    repeat (20) @(posedge clk);
    check(rise_cnt == r0 + 1, "R8", "no phases after timeout", rise_cnt - r0, 1);
    check(order[3:0] == 4'h1, "R8", "only address strobe", order[3:0], 1);
    @(negedge clk);
    check({cr_cap_addr, cr_cap_data, cr_read, cr_write} == 4'b0, "R5", "strobes low after error",
          {cr_cap_addr, cr_cap_data, cr_read, cr_write}, 0);
    check(ra && po, "R1", "ready after error", {ra, po}, 2'b11);
    mode = 0;
  endtask

  task automatic t_timeout_high();
    bit dn, er, br, po, ra; logic [15:0] rd; int r0;
    mode = 2;
    r0 = rise_cnt;
    run_access(1'b0, 16'h4444, 16'h0, dn, er, rd, br, po, ra);
    check(er && !dn, "R7", "error on stuck-high ack", {dn, er}, 2'b01);
    check(err_cyc - last_fall_cyc == LIMIT, "R7", "fall-wait timeout cycles",
          err_cyc - last_fall_cyc, LIMIT);
    repeat (10) @(posedge clk);
    check(rise_cnt == r0 + 1, "R8", "no read strobe after timeout", rise_cnt - r0, 1);
    mode = 0;
    repeat (10) @(posedge clk);
  endtask

  initial begin
    #1_500_000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_sync_delay();
    t_write(16'h0000, 16'hFFFF);   // R10 low end
    t_write(16'hFFFF, 16'h0001);   // R10 high end
    t_read(16'h0000);
    t_read(16'hFFFF);
    t_read(16'hC3A5);
    t_slow_target();
    t_timeout_low();
    t_timeout_high();
    t_read(16'h8001);              // recovery after error
    t_write(16'h5555, 16'h6666);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule